// File: doc/BRIEF.md
# Integer ALU with Five Status Flags

This block computes one 32-bit integer operation per transfer. It supports add, subtract, the three bitwise logic operations, three shifts and signed and unsigned multiply. Alongside the result it returns five status flags, which are ready to load into a processor flag register: carry, signed overflow, zero, sign and odd parity. Operand A is always a register value. Operand B is either a second register value or the 16-bit immediate from the instruction word, widened to 32 bits by a rule that depends on the operation.

Operations arrive on a valid/ready input channel and leave on a valid/ready output channel. The datapath between the two channels is combinational, and a single output register sits at the end of it. An operation accepted on a rising edge is visible at the outputs after that edge. The input channel is ready whenever the output register is empty or is being drained in the same cycle, so back-to-back transfers run at one per cycle. When the consumer withholds `out_ready` while a result is pending, the result and its flags stay frozen and `in_ready` drops. The producer must then hold its operation until it is taken.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) returns A+B modulo 2^32. Carry (flag bit 0) is the unsigned carry out. Overflow (flag bit 1) is set when two operands of equal sign give a result of the other sign.
- R2: Operation code 1 (subtract) returns A-B modulo 2^32. Carry is set when an unsigned borrow occurs (A < B). Overflow is set when operands of different sign give a result whose sign differs from A.
- R3: Operation codes 2, 3 and 4 (XOR, OR, AND) return the bitwise result, with carry and overflow both cleared.
- R4: Operation codes 5, 6 and 7 shift A by the low 5 bits of B. Code 5 shifts left and code 6 shifts right, both filling with zeros. Code 7 shifts right and fills with copies of bit 31. Carry is the last bit shifted out, or 0 for a shift amount of zero. Overflow is cleared.
- R5: Operation code 8 (signed multiply) returns the low 32 bits of the 64-bit signed product. Overflow and carry are both set when the upper 32 bits are not copies of bit 31 of the result.
- R6: Operation code 9 (unsigned multiply) returns the low 32 bits of the unsigned product. Overflow and carry are both set when the upper 32 bits are nonzero.
- R7: When `in_use_imm` is 1, `in_rs2` is ignored and B is taken from `in_imm`. For codes 0, 1, 8 and 9, `in_imm` is sign-extended. For every other code it is zero-extended.
- R8: Zero (flag bit 2) is set when the result is all zeros. Sign (flag bit 3) is bit 31 of the result. Odd (flag bit 4) is set when the result has an odd number of one bits.
- R9: Operation codes 10 to 15 return a result of 0 with flags 5'b00100.
- R10: A transfer happens when `in_valid` and `in_ready` are both high at a rising edge. The result then appears on `out_result`/`out_flags`, with `out_valid` high, after that edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. With `in_valid` low and `out_ready` high, `out_valid` falls after the next edge.
- R11: While `out_valid` is high and `out_ready` is low, `out_result` and `out_flags` hold their values, `in_ready` is low, and the operation presented at the input is not taken.
- R12: While `rst_n` is low, `out_valid` is 0, `out_result` is 0, `out_flags` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The block will accept the presented operation |
| in_op | input | 4 | Operation code |
| in_use_imm | input | 1 | 1 selects the immediate as operand B |
| in_rs1 | input | 32 | Operand A |
| in_rs2 | input | 32 | Register operand B |
| in_imm | input | 16 | Immediate operand B |
| out_valid | output | 1 | A result is held at the outputs |
| out_ready | input | 1 | The consumer takes the held result |
| out_result | output | 32 | Result |
| out_flags | output | 5 | {odd, sign, zero, overflow, carry} |

## Verification
Two events can fall in the same clock edge: the consumer takes the held result, and a new operation is loaded into the same register. The vector table provokes this by holding both `out_ready` and `in_valid` high for the whole walk. Each vector enters on the edge that empties out its predecessor, so any lost, duplicated or stale result shows up as a mismatch against the next expected value. A directed sequence then withholds `out_ready` while a second operation waits. It checks that the first result stays frozen and that the waiting operation lands only on the edge where `out_ready` returns.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int FLAG_W = 5;
  localparam int FLG_CARRY = 0;
  localparam int FLG_OVF   = 1;
  localparam int FLG_ZERO  = 2;
  localparam int FLG_SIGN  = 3;
  localparam int FLG_ODD   = 4;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_XOR  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_AND  = 4'd4,
    ALU_SHL  = 4'd5,
    ALU_SHR  = 4'd6,
    ALU_SAR  = 4'd7,
    ALU_MULS = 4'd8,
    ALU_MULU = 4'd9
  } alu_op_e;

  // Operations whose immediate is widened with its sign bit.
  function automatic logic imm_signed(input logic [3:0] op);
    return (op == ALU_ADD) || (op == ALU_SUB) || (op == ALU_MULS) || (op == ALU_MULU);
  endfunction

endpackage

// File: rtl/alu_opb_sel.sv
module alu_opb_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]        op,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] rs2,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opb
);
  import int_alu_pkg::*;

  localparam int EXT_W = DATA_W - IMM_W;

  logic ext_bit;
  logic [DATA_W-1:0] imm_wide;

  assign ext_bit  = imm_signed(op) & imm[IMM_W-1];
  assign imm_wide = {{EXT_W{ext_bit}}, imm};
  assign opb      = use_imm ? imm_wide : rs2;

endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              mul_signed,
  output logic [DATA_W-1:0] sum,
  output logic              sum_carry,
  output logic              sum_ovf,
  output logic [DATA_W-1:0] prod_lo,
  output logic              prod_ovf
);
  localparam int PROD_W = 2 * DATA_W;

  // Adder / subtractor
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_full;

  assign b_eff     = sub ? ~b : b;
  assign sum_full  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum       = sum_full[DATA_W-1:0];
  assign sum_carry = sub ? ~sum_full[DATA_W] : sum_full[DATA_W];
  assign sum_ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);

  // Single multiplier: operands widened to 2W so the low 2W bits serve both signednesses.
  logic              sx_a, sx_b;
  logic [PROD_W-1:0] ma, mb, prod;
  logic [DATA_W-1:0] prod_hi;

  assign sx_a    = mul_signed & a[DATA_W-1];
  assign sx_b    = mul_signed & b[DATA_W-1];
  assign ma      = {{DATA_W{sx_a}}, a};
  assign mb      = {{DATA_W{sx_b}}, b};
  assign prod    = ma * mb;
  assign prod_lo = prod[DATA_W-1:0];
  assign prod_hi = prod[PROD_W-1:DATA_W];

  always_comb begin
    if (mul_signed) prod_ovf = (prod_hi != {DATA_W{prod_lo[DATA_W-1]}});
    else            prod_ovf = (prod_hi != '0);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] a_rev, out_r, out_rev;
  logic              fill;
  logic [DATA_W:0]   stage [SH_W+1];
  logic              unused_b_hi;

  assign amt         = b[SH_W-1:0];
  assign unused_b_hi = ^b[DATA_W-1:SH_W];
  assign fill        = arith & ~left & a[DATA_W-1];

  // Left shifts reuse the right-shift network on the bit-reversed operand.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign a_rev[i]   = a[DATA_W-1-i];
    assign out_rev[i] = out_r[DATA_W-1-i];
  end

  // A guard bit below the LSB catches the last bit shifted out.
  assign stage[0] = {(left ? a_rev : a), 1'b0};

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt[s] ? {{SH{fill}}, stage[s][DATA_W:SH]} : stage[s];
  end

  assign out_r = stage[SH_W][DATA_W:1];
  assign carry = stage[SH_W][0];
  assign res   = left ? out_rev : out_r;

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                 res,
  input  logic                              carry,
  input  logic                              ovf,
  output logic [int_alu_pkg::FLAG_W-1:0]    flags
);
  import int_alu_pkg::*;

  always_comb begin
    flags            = '0;
    flags[FLG_CARRY] = carry;
    flags[FLG_OVF]   = ovf;
    flags[FLG_ZERO]  = (res == '0);
    flags[FLG_SIGN]  = res[DATA_W-1];
    flags[FLG_ODD]   = ^res;
  end

endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [3:0]            in_op,
  input  logic                  in_use_imm,
  input  logic [DATA_W-1:0]     in_rs1,
  input  logic [DATA_W-1:0]     in_rs2,
  input  logic [IMM_W-1:0]      in_imm,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DATA_W-1:0]     out_result,
  output logic [4:0]            out_flags
);
  import int_alu_pkg::*;

  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum, prod_lo, sh_res, res_nx;
  logic              sum_c, sum_v, prod_v, sh_c;
  logic              c_nx, v_nx;
  logic [FLAG_W-1:0] flags_nx;
  logic              in_fire;

  alu_opb_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
    .op      (in_op),
    .use_imm (in_use_imm),
    .rs2     (in_rs2),
    .imm     (in_imm),
    .opb     (opb)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a          (in_rs1),
    .b          (opb),
    .sub        (in_op == ALU_SUB),
    .mul_signed (in_op == ALU_MULS),
    .sum        (sum),
    .sum_carry  (sum_c),
    .sum_ovf    (sum_v),
    .prod_lo    (prod_lo),
    .prod_ovf   (prod_v)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .a     (in_rs1),
    .b     (opb),
    .left  (in_op == ALU_SHL),
    .arith (in_op == ALU_SAR),
    .res   (sh_res),
    .carry (sh_c)
  );

  always_comb begin
    res_nx = '0;
    c_nx   = 1'b0;
    v_nx   = 1'b0;
    case (in_op)
      ALU_ADD, ALU_SUB: begin
        res_nx = sum;
        c_nx   = sum_c;
        v_nx   = sum_v;
      end
      ALU_XOR: res_nx = in_rs1 ^ opb;
      ALU_OR:  res_nx = in_rs1 | opb;
      ALU_AND: res_nx = in_rs1 & opb;
      ALU_SHL, ALU_SHR, ALU_SAR: begin
        res_nx = sh_res;
        c_nx   = sh_c;
      end
      ALU_MULS, ALU_MULU: begin
        res_nx = prod_lo;
        c_nx   = prod_v;
        v_nx   = prod_v;
      end
      default: ;
    endcase
  end

  alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .res   (res_nx),
    .carry (c_nx),
    .ovf   (v_nx),
    .flags (flags_nx)
  );

  // Single output register with pass-through ready.
  assign in_ready = ~out_valid | out_ready;
  assign in_fire  = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else if (in_fire) begin
      out_valid  <= 1'b1;
      out_result <= res_nx;
      out_flags  <= flags_nx;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [4:0]        out_flags
);

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags))); // R11

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[2] == (out_result == '0))); // R8

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3] == out_result[DATA_W-1])); // R8

  AST_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[4] == ^out_result)); // R8

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op >= 4'd2) && (in_op <= 4'd4)) |=> (out_flags[1:0] == 2'b00)); // R3

  AST_SHIFT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op >= 4'd5) && (in_op <= 4'd7)) |=> !out_flags[1]); // R4

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op >= 4'd10)) |=> (out_result == '0 && out_flags == 5'b00100)); // R9

endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_use_imm = 1'b0;
  logic [31:0] in_rs1 = '0;
  logic [31:0] in_rs2 = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic [4:0]  out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  int_alu dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_use_imm(in_use_imm),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic        use_imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] res;
    logic [4:0]  flg;
  } vec_t;

  localparam int NVEC = 26;
  // flags = {odd, sign, zero, ovf, carry}
  localparam vec_t VEC [NVEC] = '{
    '{4'd1, 4'd0, 1'b0, 32'd5,        32'd7,        16'h0, 32'h0000000C, 5'h00}, // R1
    '{4'd1, 4'd0, 1'b0, 32'hFFFFFFFF, 32'd1,        16'h0, 32'h00000000, 5'h05}, // R1 carry out
    '{4'd1, 4'd0, 1'b0, 32'h7FFFFFFF, 32'd1,        16'h0, 32'h80000000, 5'h1A}, // R1 overflow
    '{4'd2, 4'd1, 1'b0, 32'd3,        32'd5,        16'h0, 32'hFFFFFFFE, 5'h19}, // R2 borrow
    '{4'd2, 4'd1, 1'b0, 32'h80000000, 32'd1,        16'h0, 32'h7FFFFFFF, 5'h12}, // R2 overflow
    '{4'd2, 4'd1, 1'b0, 32'd7,        32'd7,        16'h0, 32'h00000000, 5'h04}, // R2 zero
    '{4'd3, 4'd2, 1'b0, 32'hF0F0F0F0, 32'h0F0F0F0F, 16'h0, 32'hFFFFFFFF, 5'h08}, // R3 xor
    '{4'd3, 4'd4, 1'b0, 32'h12345678, 32'h0000FFFF, 16'h0, 32'h00005678, 5'h00}, // R3 and
    '{4'd3, 4'd3, 1'b0, 32'd1,        32'd6,        16'h0, 32'h00000007, 5'h10}, // R3 or
    '{4'd4, 4'd5, 1'b0, 32'h80000001, 32'd1,        16'h0, 32'h00000002, 5'h11}, // R4 shl carry
    '{4'd4, 4'd5, 1'b0, 32'h40000000, 32'h21,       16'h0, 32'h80000000, 5'h18}, // R4 amount low 5 bits
    '{4'd4, 4'd6, 1'b0, 32'h00000003, 32'd1,        16'h0, 32'h00000001, 5'h11}, // R4 shr carry
    '{4'd4, 4'd7, 1'b0, 32'h80000000, 32'd4,        16'h0, 32'hF8000000, 5'h18}, // R4 sar sign fill
    '{4'd4, 4'd6, 1'b0, 32'h80000000, 32'd4,        16'h0, 32'h08000000, 5'h10}, // R4 shr zero fill
    '{4'd4, 4'd7, 1'b0, 32'h80000001, 32'd0,        16'h0, 32'h80000001, 5'h08}, // R4 zero amount
    '{4'd5, 4'd8, 1'b0, 32'hFFFFFFFD, 32'd5,        16'h0, 32'hFFFFFFF1, 5'h18}, // R5 -3*5
    '{4'd5, 4'd8, 1'b0, 32'h00010000, 32'h00010000, 16'h0, 32'h00000000, 5'h07}, // R5 overflow
    '{4'd6, 4'd9, 1'b0, 32'hFFFFFFFF, 32'd2,        16'h0, 32'hFFFFFFFE, 5'h1B}, // R6 overflow
    '{4'd5, 4'd8, 1'b0, 32'hFFFFFFFF, 32'd2,        16'h0, 32'hFFFFFFFE, 5'h18}, // R5 no overflow
    '{4'd6, 4'd9, 1'b0, 32'h00010000, 32'h0000FFFF, 16'h0, 32'hFFFF0000, 5'h08}, // R6 no overflow
    '{4'd7, 4'd0, 1'b1, 32'd10,       32'h0,        16'hFFFF, 32'h00000009, 5'h01}, // R7 add sign-ext
    '{4'd7, 4'd2, 1'b1, 32'd0,        32'hFFFFFFFF, 16'hFFFF, 32'h0000FFFF, 5'h00}, // R7 xor zero-ext
    '{4'd7, 4'd1, 1'b1, 32'd0,        32'h0,        16'h0001, 32'hFFFFFFFF, 5'h09}, // R7 sub imm
    '{4'd7, 4'd5, 1'b1, 32'd1,        32'hFFFFFFFF, 16'h0004, 32'h00000010, 5'h10}, // R7 rs2 ignored
    '{4'd9, 4'd12, 1'b0, 32'd5,       32'd6,        16'h0, 32'h00000000, 5'h04}, // R9 undefined
    '{4'd7, 4'd8, 1'b1, 32'd3,        32'h0,        16'hFFFE, 32'hFFFFFFFA, 5'h08}  // R7 mul imm
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic imm_sel, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm);
    in_op = op; in_use_imm = imm_sel; in_rs1 = a; in_rs2 = b; in_imm = imm;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R12 out_result in reset", out_result, 32'd0);
    check("R12 out_flags in reset", {27'd0, out_flags}, 32'd0);
    check("R12 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // Vector walk, back to back: load and drain on the same edge (R10)
    out_ready = 1'b1;
    for (int i = 0; i <= NVEC; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check($sformatf("R%0d vector %0d out_valid", VEC[i-1].req, i-1), {31'd0, out_valid}, 32'd1);
        check($sformatf("R%0d vector %0d result", VEC[i-1].req, i-1), out_result, VEC[i-1].res);
        check($sformatf("R%0d vector %0d flags", VEC[i-1].req, i-1), {27'd0, out_flags}, {27'd0, VEC[i-1].flg});
      end
      if (i < NVEC) begin
        drive(VEC[i].op, VEC[i].use_imm, VEC[i].a, VEC[i].b, VEC[i].imm);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R10 drain clears out_valid", {31'd0, out_valid}, 32'd0);

    // R11: back-pressure
    out_ready = 1'b0;
    drive(4'd0, 1'b0, 32'd1, 32'd2, 16'h0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 first result", out_result, 32'd3);
    check("R11 in_ready low when blocked", {31'd0, in_ready}, 32'd0);
    drive(4'd1, 1'b0, 32'd9, 32'd4, 16'h0);
    repeat (3) begin
      @(negedge clk);
      check("R11 result held", out_result, 32'd3);
      check("R11 flags held", {27'd0, out_flags}, 32'd0);
      check("R11 out_valid held", {31'd0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R11 waiting op taken on release", out_result, 32'd5);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 idle after drain", {31'd0, out_valid}, 32'd0);

    // R12: reset in mid-run clears a held result
    out_ready = 1'b0;
    drive(4'd3, 1'b0, 32'hA5A5A5A5, 32'h0, 16'h0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 or loaded before reset", out_result, 32'hA5A5A5A5);
    rst_n = 1'b0;
    #1;
    check("R12 reset clears out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 reset clears result", out_result, 32'd0);
    check("R12 reset clears flags", {27'd0, out_flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule